// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

The block buffers bytes coming out of a serial receiver until a host consumes them. A deserializer hands over each byte with a one-cycle push strobe, and a line-break detector signals a break with its own strobe. The block stores a zero byte for each break and raises a one-cycle break-change pulse for the interrupt logic. The host takes the oldest byte with a one-cycle read strobe. The byte being read appears combinationally on the read data port while the strobe is high.

The upstream source is told whether it may deliver through a can-accept output. This output is high only while the receiver is enabled and the queue is not full. If a byte or a break still arrives while the queue is full, it replaces the newest stored byte instead of being dropped. A flush input, driven by the receiver-reset command, empties the queue at once.

Control is a three-state machine on the occupancy:
- `Q_EMPTY`: no bytes held.
- `Q_PARTIAL`: between one and DEPTH-1 bytes held.
- `Q_FULL`: DEPTH bytes held.

Named transitions:
- *fill*, EMPTY to PARTIAL: a push into the empty queue. When DEPTH is 1, this push goes straight to FULL.
- *top-up*, PARTIAL to FULL: a push that brings the count to DEPTH.
- *drain*, FULL to PARTIAL: a read with no push.
- *last-read*, PARTIAL to EMPTY: a read of the only byte with no push.
- *overwrite*, FULL to FULL: a push with no read.
- *swap*, FULL to FULL or PARTIAL to PARTIAL: a read and a push in the same cycle.
- *idle-read*, EMPTY to EMPTY: a read of the empty queue.
- *flush*, any state to EMPTY.

Top module: `rxq_fifo`

## Requirements
- R1: Bytes leave in the order they were stored, and up to DEPTH (default 4) bytes are held.
- R2: Every accepted push sets `rx_ready` from the next cycle. The push that brings the count to DEPTH also sets `full`.
- R3: A push accepted while DEPTH bytes are held, with no read in the same cycle, replaces the most recently stored byte. The count stays at DEPTH and `full` stays high.
- R4: `brk_evt` stores a 0x00 byte under the same rules as a data push, including the overwrite rule. It also drives `brk_pulse` high for exactly the following cycle.
- R5: A read strobe while the queue is empty shows 0x00 on `rd_data` and changes no flag or stored byte.
- R6: A read strobe on a non-empty queue shows the oldest byte on `rd_data`, removes it from the next cycle and clears `full`. If it removes the last byte, `rx_ready` falls.
- R7: `can_accept` equals `rx_en` AND NOT `full`. A `push_valid` with `rx_en` low is ignored, and its byte is never stored.
- R8: `flush` empties the queue and clears `rx_ready` and `full` on the next cycle. It overrides any push or read in the same cycle.
- R9: When a read and a push occur in the same cycle, the read takes the oldest byte first. The pushed byte is then appended, so the count is unchanged and a full queue stays full.
- R10: When `brk_evt` and `push_valid` occur in the same cycle, the break byte 0x00 is stored and the data byte is dropped.
- R11: After reset, the queue is empty, `rx_ready`, `full` and `brk_pulse` are low, `rd_data` is 0x00, and `can_accept` follows `rx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; gates data pushes and can_accept |
| flush | input | 1 | Empties the queue (receiver-reset command) |
| push_valid | input | 1 | One-cycle strobe: push_data holds a received byte |
| push_data | input | DATA_W | Received byte |
| brk_evt | input | 1 | One-cycle strobe: a line break was detected |
| rd_strobe | input | 1 | Host read of the oldest byte |
| rd_data | output | DATA_W | Oldest byte, or 0 when the queue is empty |
| rx_ready | output | 1 | At least one byte is held |
| full | output | 1 | DEPTH bytes are held |
| can_accept | output | 1 | Source may deliver a new byte |
| brk_pulse | output | 1 | One-cycle pulse after each break event |

## Verification
The bench builds the block with its defaults, DEPTH 4 and DATA_W 8. At this depth, four pushes are enough to reach the full state. Overwrite, swap-while-full and the wrap of both pointers therefore occur many times during a few thousand random cycles. Directed sequences pin down the same-cycle collisions: break against data push, flush against push and read, and read against push on a full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] head
);
    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign head = slots[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              brk_evt,
    input  logic              rd_strobe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [AW-1:0]     rd_addr,
    output logic              rx_ready,
    output logic              full,
    output logic              can_accept,
    output logic              brk_pulse
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    q_state_e      state, state_n;
    logic [CW-1:0] cnt, cnt_n, after_rd;
    logic [AW-1:0] rptr, rptr_n, wptr, wptr_n;
    logic          take_rd, take_push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_P) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? LAST_P : p - AW'(1);
    endfunction

    // Next-state and datapath decisions
    always_comb begin
        take_rd   = rd_strobe && (state != Q_EMPTY);
        take_push = brk_evt || (push_valid && rx_en);
        after_rd  = cnt - CW'(take_rd);
        wr_data   = brk_evt ? '0 : push_data;
        wr_en     = 1'b0;
        wr_addr   = wptr;
        rptr_n    = rptr;
        wptr_n    = wptr;
        cnt_n     = after_rd;
        if (flush) begin
            cnt_n  = '0;
            rptr_n = '0;
            wptr_n = '0;
        end else begin
            if (take_rd) begin
                rptr_n = ptr_inc(rptr);
            end
            if (take_push) begin
                wr_en = 1'b1;
                if (after_rd == DEPTH_C) begin
                    wr_addr = ptr_dec(wptr);
                end else begin
                    wptr_n = ptr_inc(wptr);
                    cnt_n  = after_rd + CW'(1);
                end
            end
        end
        if (cnt_n == '0) begin
            state_n = Q_EMPTY;
        end else if (cnt_n == DEPTH_C) begin
            state_n = Q_FULL;
        end else begin
            state_n = Q_PARTIAL;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= Q_EMPTY;
            cnt       <= '0;
            rptr      <= '0;
            wptr      <= '0;
            brk_pulse <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            rptr      <= rptr_n;
            wptr      <= wptr_n;
            brk_pulse <= brk_evt;
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state)
            Q_EMPTY:   begin rx_ready = 1'b0; full = 1'b0; end
            Q_PARTIAL: begin rx_ready = 1'b1; full = 1'b0; end
            Q_FULL:    begin rx_ready = 1'b1; full = 1'b1; end
            default:   begin rx_ready = 1'b0; full = 1'b0; end
        endcase
    end

    assign rd_addr    = rptr;
    assign can_accept = rx_en && !full;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);

    // R2
    push_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_push && !flush) |=> rx_ready);

    // R3
    overwrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL && take_push && !rd_strobe && !flush)
        |=> (full && $stable(wptr) && $stable(rptr)));

    // R4
    brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_pulse);

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY && !take_push && !flush) |=> (state == Q_EMPTY && $stable(rptr)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rx_ready && !full));

    // R9
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rd && take_push && !flush) |=> $stable(cnt));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              brk_evt,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              full,
    output logic              can_accept,
    output logic              brk_pulse
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, head;

    rxq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .flush      (flush),
        .push_valid (push_valid),
        .push_data  (push_data),
        .brk_evt    (brk_evt),
        .rd_strobe  (rd_strobe),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rx_ready   (rx_ready),
        .full       (full),
        .can_accept (can_accept),
        .brk_pulse  (brk_pulse)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .head    (head)
    );

    assign rd_data = rx_ready ? head : '0;

    // R7
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !can_accept);
endmodule

// File: tb/tb_rxq_fifo.sv
`timescale 1ns/1ps
module tb_rxq_fifo;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, flush = 1'b0, push_valid = 1'b0, brk_evt = 1'b0, rd_strobe = 1'b0;
    logic [7:0] push_data = '0;
    logic [7:0] rd_data;
    logic       rx_ready, full, can_accept, brk_pulse;

    int         n_cmp = 0, n_bad = 0;
    bit         done = 0;
    logic [7:0] q[$];
    bit         prev_brk = 0;

    always #5 clk = ~clk;

    rxq_fifo #(.DEPTH(DEPTH), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush),
        .push_valid(push_valid), .push_data(push_data), .brk_evt(brk_evt),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
        .full(full), .can_accept(can_accept), .brk_pulse(brk_pulse)
    );

    function automatic int exp_head();
        return (q.size() == 0) ? 0 : int'(q[0]);
    endfunction

    function automatic bit exp_full();
        return q.size() == DEPTH;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit p, logic [7:0] d, bit b, bit r, bit f, bit en);
        @(negedge clk);
        push_valid = p; push_data = d; brk_evt = b; rd_strobe = r; flush = f; rx_en = en;
        #3;
        chk(tag, "rd_data", int'(rd_data), exp_head());
        chk(tag, "rx_ready", int'(rx_ready), int'(q.size() != 0));
        chk(tag, "full", int'(full), int'(exp_full()));
        chk(tag, "can_accept", int'(can_accept), int'(en && !exp_full()));
        chk(tag, "brk_pulse", int'(brk_pulse), int'(prev_brk));
        @(posedge clk);
        prev_brk = b;
        if (f) begin
            q.delete();
        end else begin
            if (r && q.size() != 0) void'(q.pop_front());
            if (b || (p && en)) begin
                logic [7:0] v;
                v = b ? 8'h00 : d;
                if (q.size() == DEPTH) q[DEPTH-1] = v;
                else q.push_back(v);
            end
        end
    endtask

    task automatic idle(string tag, bit en);
        step(tag, 0, 8'h00, 0, 0, 0, en);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R11", 1);
        idle("R11", 0);
        // R2: fill to depth
        step("R2", 1, 8'hA1, 0, 0, 0, 1);
        step("R2", 1, 8'hA2, 0, 0, 0, 1);
        step("R2", 1, 8'hA3, 0, 0, 0, 1);
        step("R2", 1, 8'hA4, 0, 0, 0, 1);
        idle("R2", 1);
        // R3: overwrite newest while full
        step("R3", 1, 8'h55, 0, 0, 0, 1);
        idle("R3", 1);
        // R6: drain in order
        for (int i = 0; i < 4; i++) step("R6", 0, 8'h00, 0, 1, 0, 1);
        // R5: read of empty
        step("R5", 0, 8'h00, 0, 1, 0, 1);
        step("R5", 0, 8'h00, 0, 1, 0, 1);
        // R7: push with receiver disabled
        step("R7", 1, 8'h77, 0, 0, 0, 0);
        idle("R7", 0);
        // R4: break inserts zero, pulse follows
        step("R4", 1, 8'h10, 0, 0, 0, 1);
        step("R4", 0, 8'h00, 1, 0, 0, 1);
        idle("R4", 1);
        // R10: break and data together
        step("R10", 1, 8'hEE, 1, 0, 0, 1);
        idle("R10", 1);
        for (int i = 0; i < 3; i++) step("R1", 0, 8'h00, 0, 1, 0, 1);
        // R9: read and push together on a full queue
        for (int i = 0; i < 4; i++) step("R9", 1, 8'hC0 + 8'(i), 0, 0, 0, 1);
        step("R9", 1, 8'hCC, 0, 1, 0, 1);
        idle("R9", 1);
        step("R9", 1, 8'hCD, 0, 1, 0, 1);
        // R4 overwrite by break while full
        step("R4", 0, 8'h00, 1, 0, 0, 1);
        for (int i = 0; i < 4; i++) step("R1", 0, 8'h00, 0, 1, 0, 1);
        // R8: flush beats push and read
        step("R8", 1, 8'h31, 0, 0, 0, 1);
        step("R8", 1, 8'h32, 0, 0, 0, 1);
        step("R8", 1, 8'h33, 0, 1, 1, 1);
        idle("R8", 1);
        // R1: random traffic
        for (int i = 0; i < 4000; i++) begin
            bit p, b, r, f, en;
            p  = ($urandom_range(99) < 50);
            b  = ($urandom_range(99) < 5);
            r  = ($urandom_range(99) < 40);
            f  = ($urandom_range(99) < 3);
            en = ($urandom_range(99) < 85);
            step("R1", p, 8'($urandom_range(255)), b, r, f, en);
        end
        idle("R1", 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule